// File: doc/BRIEF.md
# Writeback Stage with Branch Redirect

This block is the last stage of an in-order pipeline. Each cycle it may retire one finished instruction. The instruction arrives as a 2-bit kind code, a jump-and-link flag and a result word. The stage never stalls, so a retiring instruction completes in the cycle it is presented. Destination registers are not carried with the instruction. The issue logic reserves them ahead of time by pushing register indices into an in-order queue held in this stage. Each data-producing instruction then consumes the oldest reservation.

Control transfers are resolved here and nowhere else. For a jump-kind instruction the result word is the target address. If the target equals the current program counter, the transfer was not taken and nothing happens. If it differs, the stage takes the redirect:
- it raises a combinational flush to all earlier stages in that same cycle;
- it loads the program counter with the target;
- it empties the reservation queue;
- for jump-and-link only, it writes the return address into register 1.

Indices at or above the general-purpose register count name vector registers. This stage never writes them, but their reservations are still consumed. An asynchronous read port gives access to the register file.

Top module: `writeback_stage`

## Requirements
- R1: After reset, `pc` equals the RESET_PC parameter (default 0x100), `pend_count` is 0, `flush` is 0 and every register reads 0.
- R2: Kind codes: 2'b00 register-type, 2'b01 immediate-type, 2'b10 jump, 2'b11 invalid. A retiring register-type or immediate-type instruction pops the oldest reservation and writes its result into that register, in reservation order.
- R3: A register-type or immediate-type instruction that retires while the queue is empty writes no register, and `pend_count` stays 0.
- R4: A popped index at or above NREG (32) writes no general-purpose register, including the entry that shares its low index bits. The reservation is still consumed.
- R5: A write aimed at register 0 is discarded, and register 0 always reads 0.
- R6: A jump whose target equals `pc` keeps `flush` at 0, leaves `pc` and the queue unchanged, and does not write register 1 even when the link flag is set.
- R7: A jump whose target differs from `pc` drives `flush` high in its own cycle. At the next edge `pc` takes the target and the queue empties. A reservation pushed in that same cycle is discarded.
- R8: A taken jump with the link flag set writes the old `pc` plus one into register 1.
- R9: An invalid-kind instruction changes no register, does not touch `pc` and does not pop the queue.
- R10: The queue holds DEPTH (8) entries. A reservation pushed while it is full is dropped, and `pend_count` never exceeds DEPTH.
- R11: A reservation and a popping retirement in the same cycle both take effect, so `pend_count` is unchanged and the order is kept.
- R12: `flush` is high only while a jump-kind instruction is retiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_valid | input | 1 | Push a destination reservation |
| rsv_idx | input | IDX_W (6) | Reserved register index |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_kind | input | 2 | Instruction kind code |
| retire_link | input | 1 | Instruction is jump-and-link |
| retire_result | input | XLEN (32) | Result value or jump target |
| rd_idx | input | log2(NREG) (5) | Register read address |
| rd_data | output | XLEN (32) | Register read data |
| pc | output | XLEN (32) | Program counter |
| flush | output | 1 | Flush all earlier stages |
| pend_count | output | log2(DEPTH+1) (4) | Reservations held |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a reservation push and a popping retirement. The bench provokes it by pushing one index while a register-type instruction retires. It then checks two things: the count holds steady, and the two results reach the two registers in order.

The second pair is a taken redirect and a new reservation. The bench provokes it by pushing an index during a taken jump. It then judges that the queue is empty afterwards, and that a later data instruction writes neither the older nor the discarded register.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    KIND_REG  = 2'b00,
    KIND_IMM  = 2'b01,
    KIND_JUMP = 2'b10,
    KIND_NONE = 2'b11
  } instr_kind_e;
endpackage

// File: rtl/wb_pend_queue.sv
module wb_pend_queue #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop_req,
  input  logic             clear,
  output logic             head_valid,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] count
);
  logic [IDX_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req && !full && !clear;
  assign pop_ok  = pop_req && !empty && !clear;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (clear) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_ptr_q] <= push_idx;
  end

  assign head_valid = !empty;
  assign head_idx   = slot_q[rd_ptr_q];
  assign count      = cnt_q;
endmodule

// File: rtl/wb_gpr_file.sv
module wb_gpr_file #(
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [RA_W-1:0]  rd_idx,
  output logic [XLEN-1:0]  rd_data
);
  logic [XLEN-1:0] regs_q [NREG];
  logic [NREG-1:0] entry_we;

  for (genvar g = 0; g < NREG; g++) begin : g_we
    if (g == 0) begin : g_zero
      assign entry_we[g] = 1'b0;
    end else begin : g_live
      assign entry_we[g] = wr_en && (wr_idx == IDX_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (entry_we[i]) regs_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = (rd_idx == '0) ? '0 : regs_q[rd_idx];
endmodule

// File: rtl/wb_redirect.sv
module wb_redirect
  import wb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            live,
  input  logic [1:0]      kind,
  input  logic            link,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] cur_pc,
  output logic            taken,
  output logic            link_wr,
  output logic [XLEN-1:0] link_data
);
  instr_kind_e k;
  assign k         = instr_kind_e'(kind);
  assign taken     = live && (k == KIND_JUMP) && (target != cur_pc);
  assign link_wr   = taken && link;
  assign link_data = cur_pc + XLEN'(1);
endmodule

// File: rtl/writeback_stage.sv
module writeback_stage
  import wb_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter int          IDX_W    = 6,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rsv_valid,
  input  logic [IDX_W-1:0]           rsv_idx,
  input  logic                       retire_valid,
  input  logic [1:0]                 retire_kind,
  input  logic                       retire_link,
  input  logic [XLEN-1:0]            retire_result,
  input  logic [$clog2(NREG)-1:0]    rd_idx,
  output logic [XLEN-1:0]            rd_data,
  output logic [XLEN-1:0]            pc,
  output logic                       flush,
  output logic [$clog2(DEPTH+1)-1:0] pend_count
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int LINK_RG = 1;

  logic [1:0]       rst_pipe_q;
  logic             core_rst_n;
  logic             live, is_data, taken, link_wr;
  logic             head_valid, data_wr;
  logic [IDX_W-1:0] head_idx;
  logic [XLEN-1:0]  link_data;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [XLEN-1:0]  wr_data;
  logic [XLEN-1:0]  pc_q, pc_d;
  logic             pc_en;
  logic [CNT_W-1:0] cnt;
  instr_kind_e      kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  assign live    = retire_valid && core_rst_n;
  assign kind    = instr_kind_e'(retire_kind);
  assign is_data = live && (kind == KIND_REG || kind == KIND_IMM);

  wb_redirect #(.XLEN(XLEN)) u_redirect (
    .live      (live),
    .kind      (retire_kind),
    .link      (retire_link),
    .target    (retire_result),
    .cur_pc    (pc_q),
    .taken     (taken),
    .link_wr   (link_wr),
    .link_data (link_data)
  );

  wb_pend_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_queue (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .push_req   (rsv_valid && core_rst_n),
    .push_idx   (rsv_idx),
    .pop_req    (is_data),
    .clear      (taken),
    .head_valid (head_valid),
    .head_idx   (head_idx),
    .count      (cnt)
  );

  assign data_wr = is_data && head_valid && (head_idx < IDX_W'(NREG));

  always_comb begin
    wr_en   = data_wr || link_wr;
    wr_idx  = head_idx;
    wr_data = retire_result;
    if (link_wr) begin
      wr_idx  = IDX_W'(LINK_RG);
      wr_data = link_data;
    end
  end

  wb_gpr_file #(.NREG(NREG), .XLEN(XLEN), .IDX_W(IDX_W)) u_gpr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  assign pc_en = taken;
  assign pc_d  = retire_result;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  pc_q <= XLEN'(RESET_PC);
    else if (pc_en)   pc_q <= pc_d;
  end

  assign pc         = pc_q;
  assign flush      = taken;
  assign pend_count = cnt;
endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsv_valid,
  input logic             retire_valid,
  input logic [1:0]       retire_kind,
  input logic [XLEN-1:0]  retire_result,
  input logic [XLEN-1:0]  pc,
  input logic             flush,
  input logic [CNT_W-1:0] pend_count
);
  AST_FLUSH_ONLY_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (retire_valid && retire_kind == 2'b10)); // R12

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(pc)); // R6

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pc == $past(retire_result))); // R7

  AST_QUEUE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_count == '0)); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_count <= CNT_W'(DEPTH)); // R10

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_kind == 2'b11 && !rsv_valid) |=> $stable(pend_count)); // R9
endmodule

bind writeback_stage wb_checker #(.DEPTH(DEPTH), .XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rsv_valid     (rsv_valid),
  .retire_valid  (retire_valid),
  .retire_kind   (retire_kind),
  .retire_result (retire_result),
  .pc            (pc),
  .flush         (flush),
  .pend_count    (pend_count)
);

// File: tb/writeback_stage_test.sv
module writeback_stage_test;
  localparam int XLEN = 32, NREG = 32, IDX_W = 6, DEPTH = 8;
  localparam logic [31:0] RPC = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsv_valid = 1'b0, retire_valid = 1'b0, retire_link = 1'b0;
  logic [IDX_W-1:0] rsv_idx = '0;
  logic [1:0] retire_kind = 2'b00;
  logic [XLEN-1:0] retire_result = '0;
  logic [4:0] rd_idx = '0;
  logic [XLEN-1:0] rd_data, pc;
  logic flush;
  logic [3:0] pend_count;

  int checks = 0, errors = 0;
  logic fl_seen;
  bit done = 0;

  typedef struct { logic [4:0] a; logic [31:0] v; string req; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  writeback_stage #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W), .DEPTH(DEPTH), .RESET_PC(RPC)) uut (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_idx(rsv_idx),
    .retire_valid(retire_valid), .retire_kind(retire_kind), .retire_link(retire_link),
    .retire_result(retire_result), .rd_idx(rd_idx), .rd_data(rd_data), .pc(pc),
    .flush(flush), .pend_count(pend_count));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_reg(input int a, input int v, input string req);
    exp_t e;
    e.a = 5'(a); e.v = 32'(v); e.req = req;
    sb.push_back(e);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  // one cycle of stimulus, flush sampled before the edge
  task automatic drive(input logic rv, input int ri, input logic tv,
                       input logic [1:0] tk, input logic tl, input int tr);
    @(negedge clk);
    rsv_valid = rv; rsv_idx = IDX_W'(ri);
    retire_valid = tv; retire_kind = tk; retire_link = tl; retire_result = 32'(tr);
    #1 fl_seen = flush;
    @(posedge clk);
    #1;
    rsv_valid = 1'b0; retire_valid = 1'b0; retire_link = 1'b0;
  endtask

  task automatic reserve(input int ri);
    drive(1'b1, ri, 1'b0, 2'b00, 1'b0, 0);
  endtask

  task automatic retire(input logic [1:0] tk, input logic tl, input int tr);
    drive(1'b0, 0, 1'b1, tk, tl, tr);
  endtask

  // monitor: pops expected register contents and compares
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        rd_idx = e.a;
        #1 check(rd_data == e.v, e.req, $sformatf("reg %0d", e.a), rd_data, e.v);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 20000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(pc == RPC, "R1", "pc", pc, RPC);
    check(pend_count == 0, "R1", "count", pend_count, 0);
    check(flush == 1'b0, "R1", "flush", flush, 0);
    for (int i = 0; i < 4; i++) expect_reg(i, 0, "R1");
    drain();

    // R2 R4: in-order pops, vector index consumed
    reserve(5); reserve(7); reserve(40);
    check(pend_count == 3, "R2", "count", pend_count, 3);
    retire(2'b00, 1'b0, 32'hA1);
    retire(2'b01, 1'b0, 32'hB2);
    check(fl_seen == 1'b0, "R12", "flush on imm", fl_seen, 0);
    retire(2'b00, 1'b0, 32'hC3);
    check(pend_count == 0, "R4", "count", pend_count, 0);
    expect_reg(5, 32'hA1, "R2"); expect_reg(7, 32'hB2, "R2");
    expect_reg(8, 0, "R4");
    drain();

    // R3: empty queue
    retire(2'b00, 1'b0, 32'hDD);
    check(pend_count == 0, "R3", "count", pend_count, 0);
    expect_reg(5, 32'hA1, "R3"); expect_reg(7, 32'hB2, "R3");
    drain();

    // R5: register 0
    reserve(0);
    retire(2'b00, 1'b0, 32'h1234);
    expect_reg(0, 0, "R5");
    drain();

    // R11: push and pop together
    reserve(9);
    drive(1'b1, 10, 1'b1, 2'b00, 1'b0, 32'hD4);
    check(pend_count == 1, "R11", "count", pend_count, 1);
    retire(2'b01, 1'b0, 32'hE5);
    expect_reg(9, 32'hD4, "R11"); expect_reg(10, 32'hE5, "R11");
    drain();

    // R10: overfill
    for (int i = 0; i < DEPTH + 2; i++) reserve(11 + i);
    check(pend_count == DEPTH, "R10", "count", pend_count, DEPTH);
    for (int i = 0; i < DEPTH + 1; i++) retire(2'b00, 1'b0, 100 + i);
    check(pend_count == 0, "R10", "count after drain", pend_count, 0);
    expect_reg(11, 100, "R10"); expect_reg(18, 107, "R10"); expect_reg(19, 0, "R10");
    drain();

    // R9 invalid, R6 not-taken jump
    reserve(21);
    retire(2'b11, 1'b0, 32'h55);
    check(pend_count == 1, "R9", "count", pend_count, 1);
    check(pc == RPC, "R9", "pc", pc, RPC);
    retire(2'b10, 1'b1, RPC);
    check(fl_seen == 1'b0, "R6", "flush", fl_seen, 0);
    check(pc == RPC, "R6", "pc", pc, RPC);
    check(pend_count == 1, "R6", "count", pend_count, 1);
    expect_reg(1, 0, "R6"); expect_reg(21, 0, "R9");
    drain();
    retire(2'b00, 1'b0, 32'h77);
    expect_reg(21, 32'h77, "R9");
    drain();

    // R7: taken jump with colliding reservation
    reserve(22);
    drive(1'b1, 23, 1'b1, 2'b10, 1'b0, 32'h200);
    check(fl_seen == 1'b1, "R7", "flush", fl_seen, 1);
    check(pc == 32'h200, "R7", "pc", pc, 32'h200);
    check(pend_count == 0, "R7", "count", pend_count, 0);
    retire(2'b00, 1'b0, 32'h99);
    expect_reg(22, 0, "R7"); expect_reg(23, 0, "R7"); expect_reg(1, 0, "R7");
    drain();

    // R8: taken jump-and-link
    retire(2'b10, 1'b1, 32'h300);
    check(fl_seen == 1'b1, "R8", "flush", fl_seen, 1);
    check(pc == 32'h300, "R8", "pc", pc, 32'h300);
    expect_reg(1, 32'h201, "R8");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule